// File: doc/BRIEF.md
# Effective Address and Cycle Budget Unit

This unit sits beside the execution core of a 16-bit processor with a 24-bit address space. For each memory instruction, the core presents several inputs: the addressing mode, the operand bytes already fetched, and any 16-bit pointer word already read from memory. It also presents the direct-page base, the data bank, the two index registers and the two width flags. One cycle later the unit returns three results. The first is the 24-bit effective address. The second is the address the pointer was read from, for the indirect modes. The third is the number of cycles the instruction should take. That count includes the penalty for a misaligned direct-page base, for 16-bit data and for an index that crosses a 256-byte page.

The operand field `opnd_i` is packed little end first. Bits 7:0 hold the direct-page offset. Bits 15:0 hold the absolute address. Bits 23:0 hold the long address. The unit has no bus access of its own. The core fetches the pointer word at `ptr_o` and presents it on `ptr_word_i`. Once the pointer is valid, the core strobes the request again to obtain the final address.

Control is a two-state machine:
- `ST_IDLE` means no result was captured on the last edge.
- `ST_VALID` means a result was captured on the last edge and `done_o` is high.

It has four transitions:
- IDLE→IDLE, when there is no request.
- IDLE→VALID (capture), when a request arrives.
- VALID→VALID (chain), when back-to-back requests arrive.
- VALID→IDLE (drain), when the request drops.

Top module: `eac_unit`

## Requirements
- R1: A high `req_i` at a rising edge loads new results, and `done_o` is high in the next cycle. `done_o` is low in every cycle that follows an edge without a request. Back-to-back requests give back-to-back results.
- R2: Mode codes 1, 2 and 3 are direct, direct indexed by X, and direct indexed by Y. They produce an address in bank 0: `dp_i` + offset (+ index), wrapped to 16 bits.
- R3: When `narrow_idx_i` is 1, every mode adds only bits 7:0 of X or Y. When it is 0, the full 16 bits are added.
- R4: Modes 1, 2, 3, 7, 8 and 9 take one extra cycle when `dp_i[7:0]` is nonzero. No other mode does.
- R5: Three loads take one extra cycle when the index carries out of bits 7:0 of the 16-bit base: absolute indexed by X (mode 5), absolute indexed by Y (mode 6), and indirect then Y (mode 8). Stores (`store_i`=1) never take this extra cycle.
- R6: Absolute mode 4 takes `bank_i` as address bits 23:16. So does indirect mode 7, over the pointer word. Modes 5, 6 and 8 add the index over all 24 bits, with carry into the bank byte.
- R7: Long mode 10 passes `opnd_i` through unchanged. Long indexed mode 11 adds X modulo 2^24.
- R8: `ptr_o` depends on the mode. Modes 7 and 8 give bank 0 and `dp_i`+offset. Mode 9 gives bank 0 and `dp_i`+offset+X. All other modes give 0.
- R9: Load base counts are: immediate (0) 2, modes 1–3 4 except mode 1 at 3, modes 4–6 4, modes 7–8 5, mode 9 6, modes 10–11 5. Codes 12–15 behave as immediate, with address 0 and 2 cycles.
- R10: Store base counts are: mode 1 3, modes 2–4 4, modes 5–6 5, mode 7 5, mode 8 6, mode 9 6, mode 10 5, mode 11 6.
- R11: `wide_i`=1 (16-bit data) adds exactly one cycle in every mode.
- R12: Reset clears `done_o`, `ea_o`, `ptr_o` and `cyc_o` to 0. Without a request, all three results hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe; inputs are captured when high |
| mode_i | input | 4 | Addressing mode code (see R2–R10) |
| store_i | input | 1 | 1 = store instruction, 0 = load |
| wide_i | input | 1 | 1 = 16-bit data access |
| narrow_idx_i | input | 1 | 1 = index registers are 8 bits wide |
| opnd_i | input | 24 | Operand bytes, offset/absolute/long |
| ptr_word_i | input | 16 | Pointer word read for indirect modes |
| dp_i | input | 16 | Direct-page base |
| bank_i | input | 8 | Data bank |
| x_i | input | 16 | X index register |
| y_i | input | 16 | Y index register |
| done_o | output | 1 | Results valid |
| ea_o | output | 24 | Effective address |
| ptr_o | output | 24 | Pointer fetch address (indirect modes) |
| cyc_o | output | 4 | Total cycle count |

## Verification
Every mode is first run as a load and then as a store, with an aligned direct page and no page crossing. This pins down the two base-count tables separately. Each mode is then run with 16-bit data and full-width indexes, which isolates the flat one-cycle width penalty. Specific patterns target each hazard on its own. A base of 0x??01 or 0x??FF exposes the misaligned-page penalty, and the absolute mode shows it is not applied there. Bases just below a page edge separate the page-cross penalty on loads from the same access as a store. An index of 0xAB80 shows that narrow mode drops the high byte. Wraps at 0xFFFF and 0xFFFFFF distinguish the 16-bit direct-page wrap, the carry into the bank byte and the 24-bit long wrap.

// File: rtl/eac_pkg.sv
package eac_pkg;

    typedef enum logic [3:0] {
        AM_IMM    = 4'd0,
        AM_DIR    = 4'd1,
        AM_DIR_X  = 4'd2,
        AM_DIR_Y  = 4'd3,
        AM_ABS    = 4'd4,
        AM_ABS_X  = 4'd5,
        AM_ABS_Y  = 4'd6,
        AM_IND    = 4'd7,
        AM_IND_Y  = 4'd8,
        AM_X_IND  = 4'd9,
        AM_LONG   = 4'd10,
        AM_LONG_X = 4'd11,
        AM_RSV12  = 4'd12,
        AM_RSV13  = 4'd13,
        AM_RSV14  = 4'd14,
        AM_RSV15  = 4'd15
    } am_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } st_e;

endpackage

// File: rtl/eac_addr_gen.sv
module eac_addr_gen
    import eac_pkg::*;
#(
    parameter int REG_W     = 16,
    parameter int BANK_W    = 8,
    parameter int OFF_W     = 8,
    parameter int PAGE_BITS = 8,
    localparam int ADDR_W   = REG_W + BANK_W
) (
    input  am_e               mode_i,
    input  logic              narrow_i,
    input  logic [ADDR_W-1:0] opnd_i,
    input  logic [REG_W-1:0]  ptr_word_i,
    input  logic [REG_W-1:0]  dp_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [REG_W-1:0]  x_i,
    input  logic [REG_W-1:0]  y_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              cross_o,
    output logic              dp_mode_o
);

    localparam int NUM_IDX = 2;

    logic [REG_W-1:0]  idx_raw [NUM_IDX];
    logic [REG_W-1:0]  idx_m   [NUM_IDX];
    logic [ADDR_W-1:0] idx_ext [NUM_IDX];

    assign idx_raw[0] = x_i;
    assign idx_raw[1] = y_i;

    for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
        assign idx_m[g]   = narrow_i ? {{(REG_W-OFF_W){1'b0}}, idx_raw[g][OFF_W-1:0]}
                                     : idx_raw[g];
        assign idx_ext[g] = {{BANK_W{1'b0}}, idx_m[g]};
    end

    // carry beyond the page field of a 16-bit base
    function automatic logic page_cross(input logic [REG_W-1:0] b,
                                        input logic [REG_W-1:0] i);
        logic [REG_W:0] s;
        s = {1'b0, b} + {1'b0, i};
        return s[REG_W:PAGE_BITS] != {1'b0, b[REG_W-1:PAGE_BITS]};
    endfunction

    logic [REG_W-1:0]  dp_base, dp_x, dp_y;
    logic [ADDR_W-1:0] abs_base, ind_base;

    assign dp_base  = dp_i + {{(REG_W-OFF_W){1'b0}}, opnd_i[OFF_W-1:0]};
    assign dp_x     = dp_base + idx_m[0];
    assign dp_y     = dp_base + idx_m[1];
    assign abs_base = {bank_i, opnd_i[REG_W-1:0]};
    assign ind_base = {bank_i, ptr_word_i};

    always_comb begin
        ea_o      = '0;
        ptr_o     = '0;
        cross_o   = 1'b0;
        dp_mode_o = 1'b0;
        unique case (mode_i)
            AM_DIR: begin
                ea_o      = {{BANK_W{1'b0}}, dp_base};
                dp_mode_o = 1'b1;
            end
            AM_DIR_X: begin
                ea_o      = {{BANK_W{1'b0}}, dp_x};
                dp_mode_o = 1'b1;
            end
            AM_DIR_Y: begin
                ea_o      = {{BANK_W{1'b0}}, dp_y};
                dp_mode_o = 1'b1;
            end
            AM_ABS:   ea_o = abs_base;
            AM_ABS_X: begin
                ea_o    = abs_base + idx_ext[0];
                cross_o = page_cross(opnd_i[REG_W-1:0], idx_m[0]);
            end
            AM_ABS_Y: begin
                ea_o    = abs_base + idx_ext[1];
                cross_o = page_cross(opnd_i[REG_W-1:0], idx_m[1]);
            end
            AM_IND: begin
                ea_o      = ind_base;
                ptr_o     = {{BANK_W{1'b0}}, dp_base};
                dp_mode_o = 1'b1;
            end
            AM_IND_Y: begin
                ea_o      = ind_base + idx_ext[1];
                ptr_o     = {{BANK_W{1'b0}}, dp_base};
                cross_o   = page_cross(ptr_word_i, idx_m[1]);
                dp_mode_o = 1'b1;
            end
            AM_X_IND: begin
                ea_o      = ind_base;
                ptr_o     = {{BANK_W{1'b0}}, dp_x};
                dp_mode_o = 1'b1;
            end
            AM_LONG:   ea_o = opnd_i;
            AM_LONG_X: ea_o = opnd_i + idx_ext[0];
            default: begin
                ea_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/eac_cycle_calc.sv
module eac_cycle_calc
    import eac_pkg::*;
#(
    parameter int CYC_W = 4
) (
    input  am_e              mode_i,
    input  logic             store_i,
    input  logic             wide_i,
    input  logic             dp_mode_i,
    input  logic             dp_misaligned_i,
    input  logic             cross_i,
    output logic [CYC_W-1:0] cyc_o
);

    logic [CYC_W-1:0] base;
    logic             dp_pen, page_pen;

    always_comb begin
        unique case (mode_i)
            AM_DIR:                   base = CYC_W'(3);
            AM_DIR_X, AM_DIR_Y:       base = CYC_W'(4);
            AM_ABS:                   base = CYC_W'(4);
            AM_ABS_X, AM_ABS_Y:       base = store_i ? CYC_W'(5) : CYC_W'(4);
            AM_IND:                   base = CYC_W'(5);
            AM_IND_Y:                 base = store_i ? CYC_W'(6) : CYC_W'(5);
            AM_X_IND:                 base = CYC_W'(6);
            AM_LONG:                  base = CYC_W'(5);
            AM_LONG_X:                base = store_i ? CYC_W'(6) : CYC_W'(5);
            default:                  base = CYC_W'(2);
        endcase
    end

    assign dp_pen   = dp_mode_i & dp_misaligned_i;
    assign page_pen = cross_i & ~store_i;

    assign cyc_o = base
                 + {{(CYC_W-1){1'b0}}, wide_i}
                 + {{(CYC_W-1){1'b0}}, dp_pen}
                 + {{(CYC_W-1){1'b0}}, page_pen};

endmodule

// File: rtl/eac_unit.sv
module eac_unit
    import eac_pkg::*;
#(
    parameter int REG_W     = 16,
    parameter int BANK_W    = 8,
    parameter int OFF_W     = 8,
    parameter int PAGE_BITS = 8,
    parameter int CYC_W     = 4,
    localparam int ADDR_W   = REG_W + BANK_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_i,
    input  logic [3:0]        mode_i,
    input  logic              store_i,
    input  logic              wide_i,
    input  logic              narrow_idx_i,
    input  logic [ADDR_W-1:0] opnd_i,
    input  logic [REG_W-1:0]  ptr_word_i,
    input  logic [REG_W-1:0]  dp_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [REG_W-1:0]  x_i,
    input  logic [REG_W-1:0]  y_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [CYC_W-1:0]  cyc_o
);

    am_e               mode;
    logic [ADDR_W-1:0] ea_c, ptr_c;
    logic [CYC_W-1:0]  cyc_c;
    logic              cross_c, dp_mode_c, dp_mis_c;
    st_e               state, state_nxt;

    assign mode     = am_e'(mode_i);
    assign dp_mis_c = |dp_i[OFF_W-1:0];

    eac_addr_gen #(
        .REG_W(REG_W), .BANK_W(BANK_W), .OFF_W(OFF_W), .PAGE_BITS(PAGE_BITS)
    ) u_addr (
        .mode_i     (mode),
        .narrow_i   (narrow_idx_i),
        .opnd_i     (opnd_i),
        .ptr_word_i (ptr_word_i),
        .dp_i       (dp_i),
        .bank_i     (bank_i),
        .x_i        (x_i),
        .y_i        (y_i),
        .ea_o       (ea_c),
        .ptr_o      (ptr_c),
        .cross_o    (cross_c),
        .dp_mode_o  (dp_mode_c)
    );

    eac_cycle_calc #(.CYC_W(CYC_W)) u_cyc (
        .mode_i          (mode),
        .store_i         (store_i),
        .wide_i          (wide_i),
        .dp_mode_i       (dp_mode_c),
        .dp_misaligned_i (dp_mis_c),
        .cross_i         (cross_c),
        .cyc_o           (cyc_c)
    );

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state <= ST_IDLE;
        else       state <= state_nxt;
    end

    // capture / chain / drain
    always_comb begin
        unique case (state)
            ST_IDLE:  state_nxt = req_i ? ST_VALID : ST_IDLE;
            ST_VALID: state_nxt = req_i ? ST_VALID : ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // result registers
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ea_o  <= '0;
            ptr_o <= '0;
            cyc_o <= '0;
        end else if (req_i) begin
            ea_o  <= ea_c;
            ptr_o <= ptr_c;
            cyc_o <= cyc_c;
        end
    end

    assign done_o = (state == ST_VALID);

endmodule

// File: rtl/eac_checks.sv
module eac_checks #(
    parameter int REG_W  = 16,
    parameter int BANK_W = 8,
    parameter int CYC_W  = 4,
    localparam int ADDR_W = REG_W + BANK_W
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              req_i,
    input logic [3:0]        mode_i,
    input logic              wide_i,
    input logic [ADDR_W-1:0] opnd_i,
    input logic [REG_W-1:0]  dp_i,
    input logic              done_o,
    input logic [ADDR_W-1:0] ea_o,
    input logic [ADDR_W-1:0] ptr_o,
    input logic [CYC_W-1:0]  cyc_o
);

    a_r1_done_after_req: assert property (@(posedge clk_i) disable iff (rst_i)
        req_i |=> done_o);

    a_r1_no_done_without_req: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_i |=> !done_o);

    a_r12_hold_results: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_i |=> ($stable(ea_o) && $stable(ptr_o) && $stable(cyc_o)));

    a_r2_direct_in_bank0: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && ($past(mode_i) >= 4'd1) && ($past(mode_i) <= 4'd3))
            |-> (ea_o[ADDR_W-1:REG_W] == '0));

    a_r7_long_passthru: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && ($past(mode_i) == 4'd10)) |-> (ea_o == $past(opnd_i)));

    a_r8_ptr_zero_elsewhere: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && (($past(mode_i) < 4'd7) || ($past(mode_i) > 4'd9))) |-> (ptr_o == '0));

    a_r4_direct_count: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && ($past(mode_i) == 4'd1))
            |-> (cyc_o == CYC_W'(3) + CYC_W'($past(wide_i))
                          + CYC_W'($past(dp_i[7:0]) != 8'd0)));

    a_r9_count_range: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> ((cyc_o >= CYC_W'(2)) && (cyc_o <= CYC_W'(9))));

endmodule

bind eac_unit eac_checks #(.REG_W(REG_W), .BANK_W(BANK_W), .CYC_W(CYC_W)) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .req_i  (req_i),
    .mode_i (mode_i),
    .wide_i (wide_i),
    .opnd_i (opnd_i),
    .dp_i   (dp_i),
    .done_o (done_o),
    .ea_o   (ea_o),
    .ptr_o  (ptr_o),
    .cyc_o  (cyc_o)
);

// File: tb/sim_eac_unit.sv
module sim_eac_unit;

    typedef struct {
        logic [23:0] ea;
        logic [23:0] ptr;
        logic [3:0]  cyc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [3:0]  mode = '0;
    logic        store = 1'b0, wide = 1'b0, narrow = 1'b1;
    logic [23:0] opnd = '0;
    logic [15:0] pw = '0, dp = '0, xr = '0, yr = '0;
    logic [7:0]  bank = '0;
    logic        done;
    logic [23:0] ea, ptr;
    logic [3:0]  cyc;

    int checks = 0;
    int failures = 0;
    int wd_cnt = 0;
    logic req_seen = 1'b0;
    logic [23:0] last_ea = '0;
    exp_t q[$];

    always #10 clk = ~clk;

    eac_unit u0 (
        .clk_i(clk), .rst_i(rst), .req_i(req), .mode_i(mode), .store_i(store),
        .wide_i(wide), .narrow_idx_i(narrow), .opnd_i(opnd), .ptr_word_i(pw),
        .dp_i(dp), .bank_i(bank), .x_i(xr), .y_i(yr),
        .done_o(done), .ea_o(ea), .ptr_o(ptr), .cyc_o(cyc)
    );

    function automatic exp_t model(input logic [3:0] m, input logic st, input logic wd,
                                   input logic nr, input logic [23:0] op,
                                   input logic [15:0] p, input logic [15:0] d,
                                   input logic [15:0] x, input logic [15:0] y,
                                   input logic [7:0] db);
        exp_t r;
        logic [15:0] xi, yi, dpa;
        int base, b16;
        bit dpm, crs;
        xi = nr ? {8'h00, x[7:0]} : x;
        yi = nr ? {8'h00, y[7:0]} : y;
        dpa = d + {8'h00, op[7:0]};
        r.ea = '0; r.ptr = '0; dpm = 0; crs = 0; base = 2;
        case (m)
            4'd1:  begin r.ea = {8'h00, dpa}; base = 3; dpm = 1; end
            4'd2:  begin r.ea = {8'h00, 16'(dpa + xi)}; base = 4; dpm = 1; end
            4'd3:  begin r.ea = {8'h00, 16'(dpa + yi)}; base = 4; dpm = 1; end
            4'd4:  begin r.ea = {db, op[15:0]}; base = 4; end
            4'd5:  begin
                r.ea = {db, op[15:0]} + {8'h00, xi}; base = st ? 5 : 4;
                b16 = int'(op[15:0]); crs = ((b16 + int'(xi)) >> 8) != (b16 >> 8);
            end
            4'd6:  begin
                r.ea = {db, op[15:0]} + {8'h00, yi}; base = st ? 5 : 4;
                b16 = int'(op[15:0]); crs = ((b16 + int'(yi)) >> 8) != (b16 >> 8);
            end
            4'd7:  begin r.ptr = {8'h00, dpa}; r.ea = {db, p}; base = 5; dpm = 1; end
            4'd8:  begin
                r.ptr = {8'h00, dpa}; r.ea = {db, p} + {8'h00, yi}; base = st ? 6 : 5; dpm = 1;
                b16 = int'(p); crs = ((b16 + int'(yi)) >> 8) != (b16 >> 8);
            end
            4'd9:  begin r.ptr = {8'h00, 16'(dpa + xi)}; r.ea = {db, p}; base = 6; dpm = 1; end
            4'd10: begin r.ea = op; base = 5; end
            4'd11: begin r.ea = op + {8'h00, xi}; base = st ? 6 : 5; end
            default: begin r.ea = '0; base = 2; end
        endcase
        base = base + int'(wd) + ((dpm && d[7:0] != 8'h00) ? 1 : 0) + ((crs && !st) ? 1 : 0);
        r.cyc = 4'(base);
        return r;
    endfunction

    task automatic issue(input logic [3:0] m, input logic st, input logic wd, input logic nr,
                         input logic [23:0] op, input logic [15:0] p, input logic [15:0] d,
                         input logic [15:0] x, input logic [15:0] y, input logic [7:0] db,
                         input string tag);
        exp_t e;
        e = model(m, st, wd, nr, op, p, d, x, y, db);
        e.tag = tag;
        q.push_back(e);
        last_ea = e.ea;
        mode = m; store = st; wide = wd; narrow = nr; opnd = op; pw = p;
        dp = d; xr = x; yr = y; bank = db; req = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(posedge clk) req_seen <= rst ? 1'b0 : req;

    always @(negedge clk) begin
        if (!rst) begin
            if (done !== req_seen) begin
                checks++; failures++;
                $display("FAIL R1 done=%0b expected=%0b", done, req_seen);
            end else if (done) begin
                exp_t e;
                checks++;
                if (q.size() == 0) begin
                    failures++;
                    $display("FAIL R1 result with empty scoreboard");
                end else begin
                    e = q.pop_front();
                    if (ea !== e.ea || ptr !== e.ptr || cyc !== e.cyc) begin
                        failures++;
                        $display("FAIL %s ea=%h ptr=%h cyc=%0d expected ea=%h ptr=%h cyc=%0d",
                                 e.tag, ea, ptr, cyc, e.ea, e.ptr, e.cyc);
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 20000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        checks++;
        if (done !== 1'b0 || ea !== '0 || ptr !== '0 || cyc !== '0) begin
            failures++;
            $display("FAIL R12 reset done=%0b ea=%h ptr=%h cyc=%0d expected 0", done, ea, ptr, cyc);
        end
        rst = 1'b0;
        @(negedge clk);

        // R9 load base counts, including reserved codes
        for (int m = 0; m < 16; m++) begin
            issue(4'(m), 1'b0, 1'b0, 1'b1, 24'h001234, 16'h2000, 16'h0300,
                  16'h0005, 16'h0007, 8'h7E, "R9");
            idle(1);
        end
        // R10 store base counts
        for (int m = 1; m < 12; m++) begin
            issue(4'(m), 1'b1, 1'b0, 1'b1, 24'h001234, 16'h2000, 16'h0300,
                  16'h0005, 16'h0007, 8'h7E, "R10");
            idle(1);
        end
        // R11 16-bit data, full-width index
        for (int m = 0; m < 12; m++) begin
            issue(4'(m), 1'(m % 2), 1'b1, 1'b0, 24'h001234, 16'h2000, 16'h0300,
                  16'h0005, 16'h0007, 8'h7E, "R11");
            idle(1);
        end
        // R4 misaligned direct page
        issue(4'd1, 1'b0, 1'b0, 1'b1, 24'h000010, 16'h0, 16'h1201, 16'h0, 16'h0, 8'h00, "R4"); idle(1);
        issue(4'd7, 1'b1, 1'b1, 1'b1, 24'h000010, 16'h4000, 16'h00FF, 16'h0, 16'h0, 8'h02, "R4"); idle(1);
        issue(4'd4, 1'b0, 1'b0, 1'b1, 24'h004000, 16'h0, 16'h1201, 16'h0, 16'h0, 8'h02, "R4"); idle(1);
        // R2 direct-page wrap in bank 0
        issue(4'd1, 1'b0, 1'b0, 1'b1, 24'h000020, 16'h0, 16'hFFF0, 16'h0, 16'h0, 8'h55, "R2"); idle(1);
        issue(4'd2, 1'b0, 1'b0, 1'b0, 24'h0000FF, 16'h0, 16'hFF00, 16'h0101, 16'h0, 8'h55, "R2"); idle(1);
        // R3 narrow vs full index
        issue(4'd2, 1'b0, 1'b0, 1'b1, 24'h000010, 16'h0, 16'h0200, 16'h1234, 16'h0, 8'h00, "R3"); idle(1);
        issue(4'd3, 1'b0, 1'b0, 1'b0, 24'h000010, 16'h0, 16'h0200, 16'h0, 16'h1234, 8'h00, "R3"); idle(1);
        issue(4'd5, 1'b0, 1'b0, 1'b1, 24'h000090, 16'h0, 16'h0, 16'hAB80, 16'h0, 8'h01, "R3"); idle(1);
        // R5 page crossing, loads vs stores
        issue(4'd5, 1'b0, 1'b0, 1'b1, 24'h0010F0, 16'h0, 16'h0, 16'h0020, 16'h0, 8'h01, "R5"); idle(1);
        issue(4'd5, 1'b1, 1'b0, 1'b1, 24'h0010F0, 16'h0, 16'h0, 16'h0020, 16'h0, 8'h01, "R5"); idle(1);
        issue(4'd6, 1'b0, 1'b0, 1'b1, 24'h0010F0, 16'h0, 16'h0, 16'h0, 16'h0005, 8'h01, "R5"); idle(1);
        issue(4'd8, 1'b0, 1'b0, 1'b1, 24'h000004, 16'h20F0, 16'h0, 16'h0, 16'h0010, 8'h01, "R5"); idle(1);
        issue(4'd8, 1'b1, 1'b0, 1'b1, 24'h000004, 16'h20F0, 16'h0, 16'h0, 16'h0010, 8'h01, "R5"); idle(1);
        // R6 bank carry
        issue(4'd5, 1'b0, 1'b0, 1'b1, 24'h00FFF0, 16'h0, 16'h0, 16'h0020, 16'h0, 8'h7E, "R6"); idle(1);
        issue(4'd8, 1'b0, 1'b0, 1'b0, 24'h000000, 16'hFFFF, 16'h0, 16'h0, 16'h0001, 8'h01, "R6"); idle(1);
        // R7 long modes
        issue(4'd10, 1'b0, 1'b0, 1'b1, 24'hABCDEF, 16'h0, 16'h0, 16'h0, 16'h0, 8'h00, "R7"); idle(1);
        issue(4'd11, 1'b0, 1'b0, 1'b1, 24'hFFFFF0, 16'h0, 16'h0, 16'h0020, 16'h0, 8'h00, "R7"); idle(1);
        // R8 pointer address
        issue(4'd9, 1'b0, 1'b0, 1'b0, 24'h000010, 16'h3000, 16'h0100, 16'h00F0, 16'h0, 8'h09, "R8"); idle(1);
        issue(4'd7, 1'b0, 1'b0, 1'b1, 24'h0000F0, 16'h3000, 16'hFF20, 16'h0, 16'h0, 8'h09, "R8"); idle(1);
        // R1 back-to-back requests
        issue(4'd4, 1'b0, 1'b0, 1'b1, 24'h001111, 16'h0, 16'h0, 16'h0, 16'h0, 8'h11, "R1");
        issue(4'd10, 1'b1, 1'b1, 1'b1, 24'h222222, 16'h0, 16'h0, 16'h0, 16'h0, 8'h11, "R1");
        issue(4'd1, 1'b0, 1'b0, 1'b1, 24'h000033, 16'h0, 16'h0400, 16'h0, 16'h0, 8'h11, "R1");
        // R12 hold while idle, with inputs moving
        req = 1'b0;
        mode = 4'd10; opnd = 24'h999999;
        repeat (4) @(negedge clk);
        checks++;
        if (done !== 1'b0 || ea !== last_ea) begin
            failures++;
            $display("FAIL R12 hold done=%0b ea=%h expected done=0 ea=%h", done, ea, last_ea);
        end
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R1 %0d results missing expected 0", q.size());
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule